// File: doc/BRIEF.md
# Interrupt-to-Vector Message Controller

This block gathers 64 wired interrupt inputs and turns each into an outgoing message. The message holds an 8-bit vector and an 8-bit route byte that software programs for each line. Every input is conditioned by two per-line settings, a trigger-kind bit and an inversion bit, which select rising edge, falling edge, active-high level or active-low level. The conditioned result is the line's pending state. A line with pending state that is unmasked, allowed to send messages, and not already served takes part in arbitration. The lowest-numbered such line wins, and its vector and route go out on a valid/ready port.

Software uses a small 32-bit register bus with combinational read data and byte strobes. The per-line bit fields are spread over pairs of 32-bit words. Line n sits at bit (n mod 32) of the word at base + 4·(n/32). The route and vector bytes are laid out one byte per line and accept single-byte writes. Once a line's message is accepted, the line is not served again until software writes a 1 to its bit in the clear word. That write also drops a latched edge.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset, both mask words read 0xFFFFFFFF. The message-enable, trigger-kind, inversion and both spare words read zero, all route and vector bytes read zero, and msg_valid is low.
- R2: The bit-vector words sit at these byte offsets: mask 0x20, message-enable 0x40, trigger-kind 0x60, clear 0x80, spare-A 0xC0, spare-B 0xE0 and inversion 0x3E0. Line n maps to bit (n mod 32) of the word at offset + 4·(n/32). Every word except clear reads back what was last written to it.
- R3: A write to any bit-vector word takes effect only when all four byte strobes are set. A write with fewer strobes leaves the word unchanged.
- R4: The route byte of line n sits at byte address 0x100+n and its vector byte at 0x200+n. A word access at address A covers bytes A..A+3, with byte A+k on data bits [8k+7:8k], and each strobe bit k gates its own byte.
- R5: Writing 1 to a bit of the clear word drops that line's latched edge and its served state. Writing 0 changes nothing, and the clear word always reads zero.
- R6: With trigger-kind 1 and inversion 0, a 0-to-1 transition latches the line pending. The line stays pending until it is cleared, even after the input returns low.
- R7: With trigger-kind 1 and inversion 1, a 1-to-0 transition latches the line pending, and a 0-to-1 transition does not.
- R8: With trigger-kind 0, the line is pending exactly while its input equals the inverse of its inversion bit (high for 0, low for 1). Nothing is latched.
- R9: A line with mask bit 1 or message-enable bit 0 produces no message. Its latched edge is kept and can be sent once the line is allowed.
- R10: A message carries the winning line's vector byte on msg_vector and route byte on msg_route, as captured when it was chosen. Vector, route and valid stay unchanged while msg_valid is high and msg_ready is low.
- R11: After a line's message is accepted (valid and ready high on the same edge), that line produces no further message until its clear bit is written with 1.
- R12: When several lines are eligible in the same cycle, the message goes to the lowest-numbered line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write request, one cycle per write |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes for the write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | 64 | Interrupt inputs, already synchronous to clk |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Receiver takes the offered message |
| msg_vector | output | 8 | Vector byte of the offered message |
| msg_route | output | 8 | Route byte of the offered message |

## Verification
The trigger conditioning is exercised with four input patterns:
- A rising step on a rising-edge line, then held high and dropped. This separates a latched edge from a level, and shows that the trailing edge does not re-arm the line.
- A high-then-low pulse on a falling-edge line. This shows that the wrong-direction transition is ignored.
- A held level on an active-high line and on an active-low line. This shows that a clear re-sends while the input stays active and stays quiet once it is inactive.
- Three simultaneous rising edges in both halves of the line range. This shows lowest-number ordering and the bit split across words.

Mask, enable and zero-valued clear writes are applied to a line with a latched edge, which shows whether blocking loses or keeps the pending state. A long back-pressure stall, with the vector byte rewritten during it, shows that the message is captured at selection.

// File: rtl/irqmsg_pkg.sv
// Package: shared constants and types for the interrupt-to-vector message controller.
// Assumes a byte-addressed register bus with 32-bit words.
package irqmsg_pkg;
    localparam int unsigned MASK_OFF  = 'h020;
    localparam int unsigned MSGEN_OFF = 'h040;
    localparam int unsigned KIND_OFF  = 'h060;
    localparam int unsigned CLR_OFF   = 'h080;
    localparam int unsigned SPAREA_OFF = 'h0C0;
    localparam int unsigned SPAREB_OFF = 'h0E0;
    localparam int unsigned INV_OFF   = 'h3E0;
    localparam int unsigned ROUTE_OFF = 'h100;
    localparam int unsigned VEC_OFF   = 'h200;
    localparam int unsigned WORD_BITS = 32;

    typedef logic [7:0] tag_t;
endpackage

// File: rtl/irqmsg_regs.sv
// Module: software register file. Holds the per-line bit-vector words, the spare
// words and the per-line route/vector bytes, and emits a one-cycle clear pulse.
// Assumes NUM_LINES is a multiple of 32 and at most 256; reads are combinational.
module irqmsg_regs
    import irqmsg_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    input  logic [3:0]            wstrb,
    output logic [31:0]           rdata,
    output logic [NUM_LINES-1:0]  mask_o,
    output logic [NUM_LINES-1:0]  msgen_o,
    output logic [NUM_LINES-1:0]  kind_o,
    output logic [NUM_LINES-1:0]  inv_o,
    output logic [NUM_LINES-1:0]  clr_o,
    output tag_t [NUM_LINES-1:0]  route_o,
    output tag_t [NUM_LINES-1:0]  vector_o
);
    localparam int unsigned WORDS = NUM_LINES / WORD_BITS;
    localparam int unsigned WA    = ADDR_W - 2;

    logic [WA-1:0] widx;
    logic          full_wr;
    logic [WORDS-1:0][31:0] mask_q, msgen_q, kind_q, inv_q, sparea_q, spareb_q;
    tag_t [NUM_LINES-1:0]   route_q, vec_q;

    assign widx    = addr[ADDR_W-1:2];
    assign full_wr = wr_en && (wstrb == 4'hF);

    // True when word index idx addresses word k of the region starting at byte off.
    function automatic logic at_word(input logic [WA-1:0] idx, input int unsigned off,
                                     input int unsigned k);
        return (32'(idx) == (off >> 2) + k);
    endfunction

    // Bit-vector words: written only with all four strobes set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '1;
            msgen_q  <= '0;
            kind_q   <= '0;
            inv_q    <= '0;
            sparea_q <= '0;
            spareb_q <= '0;
        end else if (full_wr) begin
            for (int unsigned k = 0; k < WORDS; k++) begin
                if (at_word(widx, MASK_OFF, k))   mask_q[k]   <= wdata;
                if (at_word(widx, MSGEN_OFF, k))  msgen_q[k]  <= wdata;
                if (at_word(widx, KIND_OFF, k))   kind_q[k]   <= wdata;
                if (at_word(widx, INV_OFF, k))    inv_q[k]    <= wdata;
                if (at_word(widx, SPAREA_OFF, k)) sparea_q[k] <= wdata;
                if (at_word(widx, SPAREB_OFF, k)) spareb_q[k] <= wdata;
            end
        end
    end

    // Per-line route and vector bytes, each gated by its own strobe lane.
    for (genvar b = 0; b < NUM_LINES; b++) begin : g_byte
        localparam int unsigned LANE = b % 4;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route_q[b] <= '0;
                vec_q[b]   <= '0;
            end else if (wr_en && wstrb[LANE]) begin
                if (at_word(widx, ROUTE_OFF, b / 4)) route_q[b] <= wdata[8*LANE +: 8];
                if (at_word(widx, VEC_OFF, b / 4))   vec_q[b]   <= wdata[8*LANE +: 8];
            end
        end
    end

    // Clear pulse: the written ones of a full-word write to the clear region.
    always_comb begin
        clr_o = '0;
        for (int unsigned k = 0; k < WORDS; k++) begin
            if (full_wr && at_word(widx, CLR_OFF, k)) clr_o[k*WORD_BITS +: WORD_BITS] = wdata;
        end
    end

    // Read mux; the clear region and unmapped words return zero.
    always_comb begin
        rdata = '0;
        for (int unsigned k = 0; k < WORDS; k++) begin
            if (at_word(widx, MASK_OFF, k))   rdata = mask_q[k];
            if (at_word(widx, MSGEN_OFF, k))  rdata = msgen_q[k];
            if (at_word(widx, KIND_OFF, k))   rdata = kind_q[k];
            if (at_word(widx, INV_OFF, k))    rdata = inv_q[k];
            if (at_word(widx, SPAREA_OFF, k)) rdata = sparea_q[k];
            if (at_word(widx, SPAREB_OFF, k)) rdata = spareb_q[k];
        end
        for (int unsigned b = 0; b < NUM_LINES; b++) begin
            if (at_word(widx, ROUTE_OFF, b / 4)) rdata[8*(b%4) +: 8] = route_q[b];
            if (at_word(widx, VEC_OFF, b / 4))   rdata[8*(b%4) +: 8] = vec_q[b];
        end
    end

    assign mask_o   = mask_q;
    assign msgen_o  = msgen_q;
    assign kind_o   = kind_q;
    assign inv_o    = inv_q;
    assign route_o  = route_q;
    assign vector_o = vec_q;

    // Address falls in the clear region (assertion helper).
    logic in_clr;
    always_comb begin
        in_clr = 1'b0;
        for (int unsigned k = 0; k < WORDS; k++) begin
            if (at_word(widx, CLR_OFF, k)) in_clr = 1'b1;
        end
    end

    // R5
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_clr |-> (rdata == 32'h0));

    // R3
    partial_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wstrb != 4'hF)) |=> ($stable(mask_q) && $stable(msgen_q) && $stable(kind_q)));
endmodule

// File: rtl/irqmsg_line.sv
// Module: conditioning for one interrupt line. Detects the chosen edge or level,
// keeps a latched edge and a served flag, and reports whether the line may be sent.
// Assumes irq_i is already synchronous to clk.
module irqmsg_line (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic kind_i,
    input  logic inv_i,
    input  logic mask_i,
    input  logic msgen_i,
    input  logic clr_i,
    input  logic served_i,
    output logic elig_o
);
    logic prev_q;
    logic latch_q;
    logic served_q;
    logic edge_hit;
    logic level_act;

    assign edge_hit  = inv_i ? (prev_q & ~irq_i) : (irq_i & ~prev_q);
    assign level_act = ~kind_i & (irq_i ^ inv_i);

    // Previous input sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= irq_i;
    end

    // Latched edge: a new edge wins over a simultaneous clear; dropped in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= 1'b0;
        else if (!kind_i) latch_q <= 1'b0;
        else              latch_q <= (latch_q & ~clr_i) | edge_hit;
    end

    // Served flag: set on acceptance, which wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        served_q <= 1'b0;
        else if (served_i) served_q <= 1'b1;
        else if (clr_i)    served_q <= 1'b0;
    end

    assign elig_o = (latch_q | level_act) & ~mask_i & msgen_i & ~served_q;

    // R6
    edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && kind_i && !clr_i) |=> latch_q);

    // R11
    served_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (served_i && !clr_i) |=> !elig_o);
endmodule

// File: rtl/irqmsg_arb.sv
// Module: fixed-priority selection and message output register. Picks the lowest
// eligible line when idle, holds the message until accepted, then marks it served.
// Assumes at most one message in flight.
module irqmsg_arb
    import irqmsg_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LINES-1:0]         elig_i,
    input  tag_t [NUM_LINES-1:0]         route_i,
    input  tag_t [NUM_LINES-1:0]         vector_i,
    input  logic                         ready_i,
    output logic                         valid_o,
    output tag_t                         vector_o,
    output tag_t                         route_o,
    output logic [$clog2(NUM_LINES)-1:0] line_o,
    output logic [NUM_LINES-1:0]         served_o
);
    localparam int unsigned LW = $clog2(NUM_LINES);

    logic          found;
    logic [LW-1:0] pick;
    logic [LW-1:0] line_q;

    // Priority encoder: scanning downward leaves the lowest eligible line.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                found = 1'b1;
                pick  = LW'(i);
            end
        end
    end

    // Message register: load when idle, drop on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            vector_o <= '0;
            route_o  <= '0;
            line_q   <= '0;
        end else if (valid_o) begin
            if (ready_i) valid_o <= 1'b0;
        end else if (found) begin
            valid_o  <= 1'b1;
            vector_o <= vector_i[pick];
            route_o  <= route_i[pick];
            line_q   <= pick;
        end
    end

    // Served pulse for the line whose message is accepted this cycle.
    always_comb begin
        served_o = '0;
        if (valid_o && ready_i) served_o[line_q] = 1'b1;
    end

    assign line_o = line_q;

    // R10
    msg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(vector_o) && $stable(route_o)));

    // R12
    lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ((($past(elig_i) >> line_q) & NUM_LINES'(1)) != '0) &&
            (($past(elig_i) & ((NUM_LINES'(1) << line_q) - NUM_LINES'(1))) == '0));
endmodule

// File: rtl/irq_msg_ctrl.sv
// Module: top of the interrupt-to-vector message controller. Ties the register
// file, one conditioning slice per line and the arbiter together.
// Assumes irq_in is synchronous to clk and NUM_LINES is a multiple of 32.
module irq_msg_ctrl
    import irqmsg_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_en,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [3:0]           bus_wstrb,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [7:0]           msg_vector,
    output logic [7:0]           msg_route
);
    localparam int unsigned LW = $clog2(NUM_LINES);

    logic [NUM_LINES-1:0] mask_w, msgen_w, kind_w, inv_w, clr_w, elig_w, served_w;
    tag_t [NUM_LINES-1:0] route_w, vector_w;
    logic [LW-1:0]        held_line;

    irqmsg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wstrb    (bus_wstrb),
        .rdata    (bus_rdata),
        .mask_o   (mask_w),
        .msgen_o  (msgen_w),
        .kind_o   (kind_w),
        .inv_o    (inv_w),
        .clr_o    (clr_w),
        .route_o  (route_w),
        .vector_o (vector_w)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        irqmsg_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_i    (irq_in[n]),
            .kind_i   (kind_w[n]),
            .inv_i    (inv_w[n]),
            .mask_i   (mask_w[n]),
            .msgen_i  (msgen_w[n]),
            .clr_i    (clr_w[n]),
            .served_i (served_w[n]),
            .elig_o   (elig_w[n])
        );
    end

    irqmsg_arb #(.NUM_LINES(NUM_LINES)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig_i   (elig_w),
        .route_i  (route_w),
        .vector_i (vector_w),
        .ready_i  (msg_ready),
        .valid_o  (msg_valid),
        .vector_o (msg_vector),
        .route_o  (msg_route),
        .line_o   (held_line),
        .served_o (served_w)
    );

    // Previous-cycle permission per line (assertion helper).
    logic [NUM_LINES-1:0] allow_d;
    always_ff @(posedge clk) begin
        if (!rst_n) allow_d <= '0;
        else        allow_d <= ~mask_w & msgen_w;
    end

    // R9
    grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> allow_d[held_line]);
endmodule

// File: tb/irq_msg_ctrl_bench.sv
module irq_msg_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_in = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_vector, msg_route;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_msg_ctrl u_irq_msg_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_route(msg_route)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_bit(input int unsigned base, input int n, input logic v);
        logic [31:0] w;
        logic [11:0] a;
        a = 12'(base + 4 * (n / 32));
        rd(a, w);
        w[n % 32] = v;
        wr(a, w, 4'hF);
    endtask

    task automatic clear_line(input int n);
        wr(12'(32'h80 + 4 * (n / 32)), 32'h1 << (n % 32), 4'hF);
    endtask

    task automatic cfg_line(input int n, input logic kind, input logic inv,
                            input logic [7:0] vec, input logic [7:0] rte,
                            input logic en, input logic unmask);
        wr(12'(32'h100 + (n & ~3)), 32'(rte) << (8 * (n % 4)), 4'(1 << (n % 4)));
        wr(12'(32'h200 + (n & ~3)), 32'(vec) << (8 * (n % 4)), 4'(1 << (n % 4)));
        set_bit('h60, n, kind);
        set_bit('h3E0, n, inv);
        set_bit('h40, n, en);
        set_bit('h20, n, ~unmask);
    endtask

    task automatic wait_msg(output logic got, output logic [7:0] v, output logic [7:0] r);
        got = 1'b0; v = '0; r = '0;
        for (int k = 0; k < 6 && !got; k++) begin
            @(negedge clk);
            if (msg_valid) begin got = 1'b1; v = msg_vector; r = msg_route; end
        end
    endtask

    task automatic accept;
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_msg(input string req, input logic [7:0] ev, input logic [7:0] er);
        logic g; logic [7:0] v, r;
        wait_msg(g, v, r);
        chk({req, " message present"}, 32'(g), 32'h1);
        chk({req, " vector/route"}, {16'h0, v, r}, {16'h0, ev, er});
        if (g) accept();
    endtask

    task automatic expect_none(input string req);
        logic g; logic [7:0] v, r;
        wait_msg(g, v, r);
        chk({req, " no message"}, 32'(g), 32'h0);
        if (g) accept();
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd('h020, d); chk("R1 mask0", d, 32'hFFFF_FFFF);
        rd('h024, d); chk("R1 mask1", d, 32'hFFFF_FFFF);
        rd('h040, d); chk("R1 msgen0", d, 32'h0);
        rd('h064, d); chk("R1 kind1", d, 32'h0);
        rd('h3E4, d); chk("R1 inv1", d, 32'h0);
        rd('h0E0, d); chk("R1 spareB", d, 32'h0);
        rd('h13C, d); chk("R1 route", d, 32'h0);
        rd('h200, d); chk("R1 vector", d, 32'h0);
        chk("R1 msg_valid", 32'(msg_valid), 32'h0);
    endtask

    task automatic t_layout;
        logic [31:0] d;
        wr('h024, 32'h1234_5678, 4'hF); rd('h024, d); chk("R2 mask1", d, 32'h1234_5678);
        rd('h020, d); chk("R2 mask0 untouched", d, 32'hFFFF_FFFF);
        wr('h040, 32'hA5A5_0001, 4'hF); rd('h040, d); chk("R2 msgen0", d, 32'hA5A5_0001);
        wr('h064, 32'h0F0F_F0F0, 4'hF); rd('h064, d); chk("R2 kind1", d, 32'h0F0F_F0F0);
        wr('h3E0, 32'hC3C3_3C3C, 4'hF); rd('h3E0, d); chk("R2 inv0", d, 32'hC3C3_3C3C);
        wr('h0C4, 32'hDEAD_BEEF, 4'hF); rd('h0C4, d); chk("R2 spareA1", d, 32'hDEAD_BEEF);
        wr('h0E0, 32'h0BAD_F00D, 4'hF); rd('h0E0, d); chk("R2 spareB0", d, 32'h0BAD_F00D);
        wr('h080, 32'hFFFF_FFFF, 4'hF); rd('h080, d); chk("R5 clear reads zero", d, 32'h0);
        wr('h024, 32'hFFFF_FFFF, 4'hF);
        wr('h040, 32'h0, 4'hF);
        wr('h064, 32'h0, 4'hF);
        wr('h3E0, 32'h0, 4'hF);
        wr('h0C4, 32'h0, 4'hF);
        wr('h0E0, 32'h0, 4'hF);
    endtask

    task automatic t_partial;
        logic [31:0] d;
        wr('h020, 32'h0, 4'h7); rd('h020, d); chk("R3 mask partial", d, 32'hFFFF_FFFF);
        wr('h040, 32'hFFFF_FFFF, 4'h1); rd('h040, d); chk("R3 msgen partial", d, 32'h0);
    endtask

    task automatic t_bytes;
        logic [31:0] d;
        wr('h104, 32'hAABB_CCDD, 4'b0101); rd('h104, d); chk("R4 route lanes", d, 32'h00BB_00DD);
        wr('h23C, 32'h1122_3344, 4'hF);   rd('h23C, d); chk("R4 vector full", d, 32'h1122_3344);
        wr('h23C, 32'h0000_00EE, 4'h1);   rd('h23C, d); chk("R4 vector byte", d, 32'h1122_33EE);
    endtask

    task automatic t_rising;
        cfg_line(3, 1'b1, 1'b0, 8'h53, 8'h13, 1'b1, 1'b1);
        @(negedge clk) irq_in[3] = 1'b1;
        expect_msg("R6 rising", 8'h53, 8'h13);
        expect_none("R11 no resend");
        @(negedge clk) irq_in[3] = 1'b0;
        clear_line(3);
        expect_none("R6 trailing edge");
    endtask

    task automatic t_falling;
        cfg_line(40, 1'b1, 1'b1, 8'hA8, 8'h28, 1'b1, 1'b1);
        @(negedge clk) irq_in[40] = 1'b1;
        expect_none("R7 rising ignored");
        @(negedge clk) irq_in[40] = 1'b0;
        expect_msg("R7 falling", 8'hA8, 8'h28);
        clear_line(40);
    endtask

    task automatic t_level;
        cfg_line(10, 1'b0, 1'b0, 8'h4A, 8'h0A, 1'b1, 1'b1);
        @(negedge clk) irq_in[10] = 1'b1;
        expect_msg("R8 level high", 8'h4A, 8'h0A);
        expect_none("R11 level no resend");
        clear_line(10);
        expect_msg("R8 level resend after clear", 8'h4A, 8'h0A);
        @(negedge clk) irq_in[10] = 1'b0;
        clear_line(10);
        expect_none("R8 level inactive");
        cfg_line(20, 1'b0, 1'b1, 8'h54, 8'h14, 1'b1, 1'b1);
        expect_msg("R8 level low", 8'h54, 8'h14);
        @(negedge clk) irq_in[20] = 1'b1;
        clear_line(20);
        expect_none("R8 level low inactive");
    endtask

    task automatic t_block;
        cfg_line(5, 1'b1, 1'b0, 8'h45, 8'h05, 1'b1, 1'b0);
        @(negedge clk) irq_in[5] = 1'b1;
        expect_none("R9 masked");
        wr('h080, 32'h0, 4'hF);
        set_bit('h20, 5, 1'b0);
        expect_msg("R9 R5 kept after unmask and zero clear", 8'h45, 8'h05);
        @(negedge clk) irq_in[5] = 1'b0;
        clear_line(5);
        set_bit('h20, 5, 1'b1);
        @(negedge clk) irq_in[5] = 1'b1;
        @(negedge clk);
        clear_line(5);
        set_bit('h20, 5, 1'b0);
        expect_none("R5 clear drops latched edge");
        @(negedge clk) irq_in[5] = 1'b0;
        cfg_line(6, 1'b1, 1'b0, 8'h46, 8'h06, 1'b0, 1'b1);
        @(negedge clk) irq_in[6] = 1'b1;
        expect_none("R9 message disabled");
        set_bit('h40, 6, 1'b1);
        expect_msg("R9 enabled later", 8'h46, 8'h06);
        @(negedge clk) irq_in[6] = 1'b0;
        clear_line(6);
    endtask

    task automatic t_stall;
        logic g; logic [7:0] v, r;
        bit steady;
        cfg_line(12, 1'b1, 1'b0, 8'h6C, 8'h2C, 1'b1, 1'b1);
        @(negedge clk) irq_in[12] = 1'b1;
        wait_msg(g, v, r);
        chk("R10 stall message present", 32'(g), 32'h1);
        wr('h20C, 32'h0000_0099, 4'h1);
        steady = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (!msg_valid || msg_vector != 8'h6C || msg_route != 8'h2C) steady = 1'b0;
        end
        chk("R10 held while stalled", 32'(steady), 32'h1);
        accept();
        @(negedge clk) irq_in[12] = 1'b0;
        clear_line(12);
    endtask

    task automatic t_priority;
        cfg_line(50, 1'b1, 1'b0, 8'hB2, 8'h32, 1'b1, 1'b1);
        cfg_line(7,  1'b1, 1'b0, 8'h87, 8'h07, 1'b1, 1'b1);
        cfg_line(2,  1'b1, 1'b0, 8'h82, 8'h02, 1'b1, 1'b1);
        @(negedge clk) begin irq_in[50] = 1'b1; irq_in[7] = 1'b1; irq_in[2] = 1'b1; end
        expect_msg("R12 first", 8'h82, 8'h02);
        expect_msg("R12 second", 8'h87, 8'h07);
        expect_msg("R12 third", 8'hB2, 8'h32);
        @(negedge clk) begin irq_in[50] = 1'b0; irq_in[7] = 1'b0; irq_in[2] = 1'b0; end
        wr('h080, 32'h0000_0084, 4'hF);
        wr('h084, 32'h0004_0000, 4'hF);
        expect_none("R11 all served and cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_partial();
        t_bytes();
        t_rising();
        t_falling();
        t_level();
        t_block();
        t_stall();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule